// File: doc/BRIEF.md
# Time-Stamp Priority Round-Robin Grant Unit

This block picks one winner per clock among a set of flit requesters that share a path through an emulated network. This covers both arbitration inside one partition and arbitration between partitions across a crossbar. Each requester drives a valid bit and the time stamp carried by its flit. The block compares that stamp with the current simulated time. A valid requester whose stamp matches is urgent. Every other valid requester is normal.

Two round-robin pickers run in parallel. One looks only at urgent requests and the other only at normal requests. When at least one urgent request is present, the urgent picker's choice is the grant. Otherwise the normal picker's choice is the grant. The grant is combinational from the current inputs. It is offered as a valid/ready handshake: `grant_valid` says a winner is presented, and the consumer accepts it by raising `grant_ready` in the same cycle. A grant counts as used only on a cycle where both are high. Only a used grant moves the search pointer of the picker that produced it. While `grant_ready` is low, the pointers stay put, so unchanged requests keep producing the same winner. The consumer may hold `grant_ready` low for any number of cycles.

Top module: `ts_rr_arbiter`

## Requirements
- R1: With no valid requester, `grant` is all zeros and `grant_valid` is low; this includes the state straight after reset.
- R2: `grant` has at most one bit set, and a set bit always belongs to a requester whose valid bit is high.
- R3: A requester is urgent exactly when it is valid and its time stamp equals `cur_time`, whether that stamp is earlier or later. When any urgent requester exists, the winner is urgent and `grant_urgent` is high. An invalid requester with a matching stamp has no effect.
- R4: Among urgent requesters, the winner is the first urgent index at or after the urgent pointer, counting upward and wrapping from N-1 to 0. After a used urgent grant at index k, the urgent pointer becomes k+1, or 0 when k is N-1.
- R5: Among normal requesters, with no urgent request present, the same search and update rule applies using the separate normal pointer.
- R6: A used grant moves only the pointer of the class that produced it; the other class's pointer keeps its value.
- R7: While `grant_valid` is high and `grant_ready` is low, neither pointer moves, so identical inputs on the next cycle give the identical grant.
- R8: `grant_idx` is the binary index of the set bit of `grant`, and `grant_urgent` is high only with an urgent winner.
- R9: Reset sets both pointers to 0, so the lowest valid index of the winning class is chosen first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of both pointers |
| req_valid | input | N | One request bit per requester |
| req_ts | input | N*TS_W | Flit time stamps; requester i occupies bits [i*TS_W +: TS_W] |
| cur_time | input | TS_W | Current simulated time |
| grant_ready | input | 1 | Consumer accepts the presented grant this cycle |
| grant_valid | output | 1 | A winner is presented |
| grant | output | N | One-hot grant vector |
| grant_idx | output | $clog2(N) | Binary index of the winner |
| grant_urgent | output | 1 | Winner came from the urgent class |

## Verification
Every grant output depends combinationally on the inputs of the same cycle. Stimulus is applied on the falling edge, and the outputs are compared 5 ns later, before the next rising edge. A pointer change caused by a used grant takes effect at that rising edge, so it first shows in the grant of the following vector. The expected winners in the table are worked out by carrying both pointers forward by hand through the sequence, including the stalled cycles, where the pointers do not move.

// File: rtl/ts_arb_pkg.sv
package ts_arb_pkg;
  localparam int unsigned DEF_REQS = 8;
  localparam int unsigned DEF_TS_W = 16;

  typedef enum logic {
    CLS_NORMAL = 1'b0,
    CLS_URGENT = 1'b1
  } arb_class_e;
endpackage

// File: rtl/ts_arb_classify.sv
module ts_arb_classify #(
  parameter int unsigned N    = 8,
  parameter int unsigned TS_W = 16
) (
  input  logic [N-1:0]      req_valid,
  input  logic [N*TS_W-1:0] req_ts,
  input  logic [TS_W-1:0]   cur_time,
  output logic [N-1:0]      urgent_req,
  output logic [N-1:0]      normal_req
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic on_time;
    assign on_time       = (req_ts[g*TS_W +: TS_W] == cur_time);
    assign urgent_req[g] = req_valid[g] & on_time;
    assign normal_req[g] = req_valid[g] & ~on_time;
  end
endmodule

// File: rtl/ts_arb_rr.sv
module ts_arb_rr #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          any,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr;
  logic [IW-1:0] ptr_nxt;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int off = 0; off < N; off++) begin
      logic [IW:0] cand;
      cand = {1'b0, ptr} + (IW+1)'(off);
      if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
      if (!any && req[cand[IW-1:0]]) begin
        any = 1'b1;
        idx = cand[IW-1:0];
      end
    end
  end

  assign ptr_nxt = (idx == LAST) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)          ptr <= '0;
    else if (take && any) ptr <= ptr_nxt;
  end
endmodule

// File: rtl/ts_rr_arbiter.sv
module ts_rr_arbiter
  import ts_arb_pkg::*;
#(
  parameter int unsigned N    = DEF_REQS,
  parameter int unsigned TS_W = DEF_TS_W,
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_valid,
  input  logic [N*TS_W-1:0] req_ts,
  input  logic [TS_W-1:0]   cur_time,
  input  logic              grant_ready,
  output logic              grant_valid,
  output logic [N-1:0]      grant,
  output logic [IW-1:0]     grant_idx,
  output logic              grant_urgent
);
  logic [N-1:0]  urg_req, nrm_req;
  logic          urg_any, nrm_any;
  logic [IW-1:0] urg_idx, nrm_idx;
  arb_class_e    win_cls;

  ts_arb_classify #(.N(N), .TS_W(TS_W)) u_cls (
    .req_valid (req_valid),
    .req_ts    (req_ts),
    .cur_time  (cur_time),
    .urgent_req(urg_req),
    .normal_req(nrm_req)
  );

  ts_arb_rr #(.N(N), .IW(IW)) u_rr_urg (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (urg_req),
    .take (grant_ready && win_cls == CLS_URGENT),
    .any  (urg_any),
    .idx  (urg_idx)
  );

  ts_arb_rr #(.N(N), .IW(IW)) u_rr_nrm (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (nrm_req),
    .take (grant_ready && win_cls == CLS_NORMAL),
    .any  (nrm_any),
    .idx  (nrm_idx)
  );

  assign win_cls      = urg_any ? CLS_URGENT : CLS_NORMAL;
  assign grant_valid  = urg_any | nrm_any;
  assign grant_idx    = (win_cls == CLS_URGENT) ? urg_idx : nrm_idx;
  assign grant_urgent = urg_any;
  assign grant        = grant_valid ? (N'(1) << grant_idx) : '0;
endmodule

// File: rtl/ts_rr_arbiter_chk.sv
module ts_rr_arbiter_chk #(
  parameter int unsigned N    = 8,
  parameter int unsigned TS_W = 16,
  parameter int unsigned IW   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      req_valid,
  input logic [N*TS_W-1:0] req_ts,
  input logic [TS_W-1:0]   cur_time,
  input logic              grant_ready,
  input logic              grant_valid,
  input logic [N-1:0]      grant,
  input logic [IW-1:0]     grant_idx,
  input logic              grant_urgent
);
  logic on_time_pending;
  always_comb begin
    on_time_pending = 1'b0;
    for (int i = 0; i < N; i++)
      if (req_valid[i] && req_ts[i*TS_W +: TS_W] == cur_time) on_time_pending = 1'b1;
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (!grant_valid && grant == '0));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_valid_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);

  assert_urgent_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    on_time_pending |-> (grant_urgent && req_ts[grant_idx*TS_W +: TS_W] == cur_time));

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=>
      (!($stable(req_valid) && $stable(req_ts) && $stable(cur_time)) || $stable(grant)));

  assert_idx_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant[grant_idx]);
endmodule

bind ts_rr_arbiter ts_rr_arbiter_chk #(.N(N), .TS_W(TS_W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ts(req_ts),
  .cur_time(cur_time), .grant_ready(grant_ready), .grant_valid(grant_valid),
  .grant(grant), .grant_idx(grant_idx), .grant_urgent(grant_urgent)
);

// File: tb/ts_rr_arbiter_test.sv
module ts_rr_arbiter_test;
  localparam int N = 8;
  localparam int TS_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req_valid = '0;
  logic [N*TS_W-1:0] req_ts = '0;
  logic [TS_W-1:0]   cur_time = 16'd100;
  logic              grant_ready = 1'b0;
  logic              grant_valid;
  logic [N-1:0]      grant;
  logic [2:0]        grant_idx;
  logic              grant_urgent;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ts_rr_arbiter #(.N(N), .TS_W(TS_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ts(req_ts),
    .cur_time(cur_time), .grant_ready(grant_ready), .grant_valid(grant_valid),
    .grant(grant), .grant_idx(grant_idx), .grant_urgent(grant_urgent)
  );

  // {valid[7:0], on_time mask[7:0], ready, exp_valid, exp_urgent, exp_idx[2:0]}
  localparam logic [21:0] TBL [16] = '{
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R1 idle
    {8'h06, 8'h00, 1'b1, 1'b1, 1'b0, 3'd1},  // R5,R9
    {8'h06, 8'h00, 1'b1, 1'b1, 1'b0, 3'd2},  // R5
    {8'h06, 8'h00, 1'b1, 1'b1, 1'b0, 3'd1},  // R5 wrap
    {8'hA1, 8'h20, 1'b1, 1'b1, 1'b1, 3'd5},  // R3
    {8'hA1, 8'h20, 1'b0, 1'b1, 1'b1, 3'd5},  // R7 stall
    {8'hA1, 8'h20, 1'b1, 1'b1, 1'b1, 3'd5},  // R4
    {8'hA1, 8'h81, 1'b1, 1'b1, 1'b1, 3'd7},  // R4
    {8'hA1, 8'h81, 1'b1, 1'b1, 1'b1, 3'd0},  // R4 wrap
    {8'hA1, 8'h81, 1'b1, 1'b1, 1'b1, 3'd7},  // R4
    {8'hA1, 8'h00, 1'b1, 1'b1, 1'b0, 3'd5},  // R6 normal ptr kept
    {8'hA1, 8'h00, 1'b1, 1'b1, 1'b0, 3'd7},  // R5
    {8'hA1, 8'h00, 1'b1, 1'b1, 1'b0, 3'd0},  // R5 wrap
    {8'hFF, 8'h04, 1'b0, 1'b1, 1'b1, 3'd2},  // R3,R7
    {8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 3'd1},  // R5
    {8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 3'd0}   // R4
  };

  // Requesters in the mask carry cur_time; others carry one above or below it.
  task automatic apply(input logic [7:0] v, input logic [7:0] m, input logic rdy);
    @(negedge clk);
    for (int i = 0; i < N; i++)
      req_ts[i*TS_W +: TS_W] = m[i] ? cur_time : ((i % 2) ? cur_time + 16'd1 : cur_time - 16'd1);
    req_valid   = v;
    grant_ready = rdy;
    #5;
  endtask

  task automatic expect_grant(input string req, input logic ev, input logic eu, input logic [2:0] ei);
    logic [N-1:0] eg;
    eg = ev ? (N'(1) << ei) : '0;
    checks++;
    if (grant_valid !== ev || grant !== eg || (ev && (grant_idx !== ei || grant_urgent !== eu))) begin
      errors++;
      $display("FAIL %s: got valid=%0b grant=%b idx=%0d urg=%0b, expected valid=%0b grant=%b idx=%0d urg=%0b",
               req, grant_valid, grant, grant_idx, grant_urgent, ev, eg, ei, eu);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    expect_grant("R1 reset", 1'b0, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      apply(TBL[k][21:14], TBL[k][13:6], TBL[k][5]);
      expect_grant($sformatf("vector %0d", k), TBL[k][4], TBL[k][3], TBL[k][2:0]);
    end

    // R9: reset mid-run returns the normal pointer to 0 (without it, 7 would win)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(8'h82, 8'h00, 1'b1);
    expect_grant("R9 pointer reset", 1'b1, 1'b0, 3'd1);

    // R3: invalid requester with matching stamp is ignored
    apply(8'h08, 8'h40, 1'b1);
    expect_grant("R3 invalid on-time ignored", 1'b1, 1'b0, 3'd3);

    // R3: urgency follows a new cur_time
    cur_time = 16'd200;
    apply(8'h11, 8'h10, 1'b1);
    expect_grant("R3 new time", 1'b1, 1'b1, 3'd4);

    // R6: normal grant leaves urgent pointer at 5
    apply(8'h42, 8'h00, 1'b1);
    expect_grant("R6 normal step", 1'b1, 1'b0, 3'd6);
    apply(8'h4A, 8'h48, 1'b1);
    expect_grant("R6 urgent pointer kept", 1'b1, 1'b1, 3'd6);

    // R7: repeated stall holds; release then moves on
    apply(8'h4A, 8'h48, 1'b0);
    expect_grant("R7 stall a", 1'b1, 1'b1, 3'd3);
    apply(8'h4A, 8'h48, 1'b0);
    expect_grant("R7 stall b", 1'b1, 1'b1, 3'd3);
    apply(8'h4A, 8'h48, 1'b1);
    expect_grant("R7 release", 1'b1, 1'b1, 3'd3);
    apply(8'h4A, 8'h48, 1'b1);
    expect_grant("R4 after release", 1'b1, 1'b1, 3'd6);

    apply(8'h00, 8'hFF, 1'b1);
    expect_grant("R1 idle with matching stamps", 1'b0, 1'b0, 3'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule